// File: doc/BRIEF.md
# Interleaved Block Fetch Controller

This controller fills one cache line from four word-wide memory banks that share a single 32-bit data path. The cache side raises a request with a block address. The controller then spends one bus cycle presenting that address to the banks and waits out the banks' fixed access latency. After that it streams the four words back in ascending offset order, one per cycle. Each word carries a valid strobe and its offset, and the last word also carries a done flag.

Two fetch modes are chosen per request. In interleaved mode all four banks begin their slow access in the same cycle, so only the word transfers are serialised. In sequential mode the banks are started one at a time, and each word pays the full access latency plus its transfer cycle. The second mode exists to measure the gain of interleaving against a plain single-bank layout. The controller holds no data of its own beyond the outgoing word register. The bank models that answer it live in the testbench.

Top module: `ilv_fetch_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `rsp_vld`, `rsp_done` and every bit of `mem_go` are low.
- R2: A request is taken only when `req_vld` is high at a clock edge while `busy` is low. `busy` is high from the cycle after acceptance through the cycle of the last word, and low in the cycle after it. A request raised while busy is ignored: it produces no extra words and does not alter `mem_addr`.
- R3: Cycle 1 is the cycle after acceptance. In cycle 1 `mem_addr` carries the accepted block address, and `mem_addr` stays unchanged until the fetch ends. In cycle 1 `mem_go` is 4'b1111 in interleaved mode (`req_seq`=0) and 4'b0001 in sequential mode (`req_seq`=1). `mem_go` is one-hot or all ones, and is only ever non-zero while busy.
- R4: In interleaved mode word j appears (`rsp_vld` high) in cycle 1+ACC_LAT+1+j. With ACC_LAT=15 the words appear in cycles 17 to 20, and the fill costs 20 cycles.
- R5: In sequential mode word j appears in cycle ACC_LAT+2+j·(ACC_LAT+1). `mem_go` is one-hot on bit j+1 during the cycle of word j, for every j below the last. With ACC_LAT=15 the fill costs 65 cycles.
- R6: Word j is the value that bank j (bits [32j+31:32j] of `mem_rdata`) drives in the cycle before the word appears. `rsp_idx` equals j, so offsets rise 0,1,2,3.
- R7: Each accepted request yields exactly four cycles with `rsp_vld` high. `rsp_done` is high only together with the word of offset 3, and `rsp_vld` is never high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Block fetch request |
| req_addr | input | AW (16) | Block address of the request |
| req_seq | input | 1 | 1 selects sequential (one bank at a time) mode |
| busy | output | 1 | A fetch is in progress; requests are ignored |
| rsp_vld | output | 1 | A data word is present on `rsp_data` |
| rsp_data | output | DW (32) | Returned data word |
| rsp_idx | output | IW (2) | Offset of the returned word within the block |
| rsp_done | output | 1 | Marks the last word of the block |
| mem_addr | output | AW (16) | Block address presented to all banks |
| mem_go | output | NW (4) | Per-bank access start strobes |
| mem_rdata | input | NW*DW (128) | Read data from the banks, bank j in slice j |

## Verification
The bench builds the controller with its default parameters: four banks of 32-bit words, a 16-bit block address and a 15-cycle bank latency. These are the exact figures for which the 20-cycle and 65-cycle fill costs hold. Its bank models answer with a marker pattern until their access delay has run out. As a result, a controller that samples a word one cycle early returns wrong data rather than only wrong timing. Every request is swept in both modes over a set of corner addresses, with each word's cycle, offset and value computed from the latency formulas. Further runs cover back-to-back requests and requests raised while busy.

// File: rtl/ilv_fetch_pkg.sv
package ilv_fetch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2,
    ST_XFER = 2'd3
  } ilv_state_e;
endpackage

// File: rtl/ilv_fetch_seq.sv
module ilv_fetch_seq
  import ilv_fetch_pkg::*;
#(
  parameter int NW      = 4,
  parameter int AW      = 16,
  parameter int ACC_LAT = 15,
  localparam int IW     = (NW > 1) ? $clog2(NW) : 1,
  localparam int CW     = $clog2(ACC_LAT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_vld,
  input  logic [AW-1:0] req_addr,
  input  logic          req_seq,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic [NW-1:0] mem_go,
  output logic          ld,
  output logic [IW-1:0] ld_idx,
  output logic          ld_last
);
  localparam logic [IW-1:0] LAST = IW'(NW - 1);

  ilv_state_e    st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] widx;
  logic          seq_q;
  logic [IW-1:0] nidx;

  assign nidx = widx + 1'b1;

  // load strobe for the word register: end of an access wait, or
  // back-to-back transfers in interleaved mode
  always_comb begin
    ld     = 1'b0;
    ld_idx = widx;
    if (st == ST_WAIT && cnt == '0) begin
      ld     = 1'b1;
      ld_idx = widx;
    end else if (st == ST_XFER && !seq_q && widx != LAST) begin
      ld     = 1'b1;
      ld_idx = nidx;
    end
  end
  assign ld_last = (ld_idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      widx     <= '0;
      seq_q    <= 1'b0;
      busy     <= 1'b0;
      mem_addr <= '0;
      mem_go   <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_vld) begin
            st       <= ST_ADDR;
            mem_addr <= req_addr;
            seq_q    <= req_seq;
            widx     <= '0;
            busy     <= 1'b1;
            mem_go   <= req_seq ? NW'(1) : {NW{1'b1}};
          end
        end
        ST_ADDR: begin
          mem_go <= '0;
          cnt    <= CW'(ACC_LAT - 1);
          st     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            st     <= ST_XFER;
            mem_go <= (seq_q && widx != LAST) ? (NW'(1) << nidx) : '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_XFER: begin
          mem_go <= '0;
          if (widx == LAST) begin
            st   <= ST_IDLE;
            busy <= 1'b0;
          end else begin
            widx <= nidx;
            if (seq_q) begin
              st  <= ST_WAIT;
              cnt <= CW'(ACC_LAT - 1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ilv_word_sel.sv
module ilv_word_sel #(
  parameter int NW = 4,
  parameter int DW = 32,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NW*DW-1:0] mem_rdata,
  input  logic             ld,
  input  logic [IW-1:0]    ld_idx,
  input  logic             ld_last,
  output logic             rsp_vld,
  output logic [DW-1:0]    rsp_data,
  output logic [IW-1:0]    rsp_idx,
  output logic             rsp_done
);
  logic [DW-1:0] bank_w [NW];

  for (genvar g = 0; g < NW; g++) begin : g_slice
    assign bank_w[g] = mem_rdata[g*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld  <= 1'b0;
      rsp_done <= 1'b0;
      rsp_data <= '0;
      rsp_idx  <= '0;
    end else begin
      rsp_vld  <= ld;
      rsp_done <= ld & ld_last;
      if (ld) begin
        rsp_data <= bank_w[ld_idx];
        rsp_idx  <= ld_idx;
      end
    end
  end
endmodule

// File: rtl/ilv_fetch_ctrl.sv
module ilv_fetch_ctrl #(
  parameter int NW      = 4,
  parameter int DW      = 32,
  parameter int AW      = 16,
  parameter int ACC_LAT = 15,
  localparam int IW     = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_vld,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_seq,
  output logic             busy,
  output logic             rsp_vld,
  output logic [DW-1:0]    rsp_data,
  output logic [IW-1:0]    rsp_idx,
  output logic             rsp_done,
  output logic [AW-1:0]    mem_addr,
  output logic [NW-1:0]    mem_go,
  input  logic [NW*DW-1:0] mem_rdata
);
  logic          ld;
  logic [IW-1:0] ld_idx;
  logic          ld_last;

  ilv_fetch_seq #(.NW(NW), .AW(AW), .ACC_LAT(ACC_LAT)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_vld  (req_vld),
    .req_addr (req_addr),
    .req_seq  (req_seq),
    .busy     (busy),
    .mem_addr (mem_addr),
    .mem_go   (mem_go),
    .ld       (ld),
    .ld_idx   (ld_idx),
    .ld_last  (ld_last)
  );

  ilv_word_sel #(.NW(NW), .DW(DW)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .mem_rdata (mem_rdata),
    .ld        (ld),
    .ld_idx    (ld_idx),
    .ld_last   (ld_last),
    .rsp_vld   (rsp_vld),
    .rsp_data  (rsp_data),
    .rsp_idx   (rsp_idx),
    .rsp_done  (rsp_done)
  );
endmodule

// File: rtl/ilv_fetch_chk.sv
module ilv_fetch_chk #(
  parameter int NW = 4,
  parameter int AW = 16,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          rsp_vld,
  input logic          rsp_done,
  input logic [IW-1:0] rsp_idx,
  input logic [NW-1:0] mem_go,
  input logic [AW-1:0] mem_addr
);
  p_go_only_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_go != '0) |-> busy);

  p_go_shape_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mem_go) || (&mem_go));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mem_addr));

  p_done_with_word_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> rsp_vld);

  p_no_word_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rsp_vld);

  p_busy_ends_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !busy);

  p_idx_step_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld && $past(rsp_vld)) |-> (rsp_idx == IW'($past(rsp_idx) + 1'b1)));
endmodule

bind ilv_fetch_ctrl ilv_fetch_chk #(.NW(NW), .AW(AW), .IW(IW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .rsp_vld  (rsp_vld),
  .rsp_done (rsp_done),
  .rsp_idx  (rsp_idx),
  .mem_go   (mem_go),
  .mem_addr (mem_addr)
);

// File: tb/tb_ilv_fetch_ctrl.sv
`timescale 1ns/1ps
module tb_ilv_fetch_ctrl;
  localparam int NW  = 4;
  localparam int DW  = 32;
  localparam int AW  = 16;
  localparam int LAT = 15;
  localparam int IW  = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_vld = 1'b0;
  logic [AW-1:0]    req_addr = '0;
  logic             req_seq = 1'b0;
  logic             busy, rsp_vld, rsp_done;
  logic [DW-1:0]    rsp_data;
  logic [IW-1:0]    rsp_idx;
  logic [AW-1:0]    mem_addr;
  logic [NW-1:0]    mem_go;
  logic [NW*DW-1:0] mem_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ilv_fetch_ctrl #(.NW(NW), .DW(DW), .AW(AW), .ACC_LAT(LAT)) dut (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_addr(req_addr),
    .req_seq(req_seq), .busy(busy), .rsp_vld(rsp_vld), .rsp_data(rsp_data),
    .rsp_idx(rsp_idx), .rsp_done(rsp_done), .mem_addr(mem_addr),
    .mem_go(mem_go), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a, input int b);
    return {a, 16'(b)} ^ 32'h3C5A_96E1;
  endfunction

  // behavioural banks: data valid only once the access delay has elapsed
  for (genvar b = 0; b < NW; b++) begin : g_bank
    logic [AW-1:0] ba;
    logic [4:0]    bc;
    logic          arm;
    always_ff @(posedge clk) begin
      if (rst) begin
        arm <= 1'b0; bc <= '0; ba <= '0;
      end else if (mem_go[b]) begin
        arm <= 1'b1; bc <= 5'(LAT - 1); ba <= mem_addr;
      end else if (bc != 0) begin
        bc <= bc - 1'b1;
      end
    end
    assign mem_rdata[b*DW +: DW] = (arm && bc == 0) ? exp_word(ba, b)
                                                    : (32'hBAD0_0000 | 32'(b));
  end

  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
    end
  endtask

  task automatic run_req(input logic [AW-1:0] a, input logic sq, input bit poke);
    int c = 1;
    int j = 0;
    int exp_c, tot;
    req_vld = 1'b1; req_addr = a; req_seq = sq;
    @(posedge clk); @(negedge clk);
    req_vld = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", busy, 1);
    chk(mem_addr == a, "R3 address in cycle 1", mem_addr, a);
    chk(mem_go == (sq ? 4'b0001 : 4'b1111), "R3 start strobes", mem_go, sq ? 1 : 15);
    while (j < NW && c < 300) begin
      @(posedge clk); @(negedge clk);
      c++;
      if (poke) begin
        if (c == 5) begin req_vld = 1'b1; req_addr = ~a; end
        else req_vld = 1'b0;
      end
      if (mem_addr != a) chk(0, "R3 address held", mem_addr, a);
      if (rsp_vld) begin
        exp_c = sq ? (LAT + 2 + j * (LAT + 1)) : (LAT + 2 + j);
        chk(c == exp_c, sq ? "R5 word cycle" : "R4 word cycle", c, exp_c);
        chk(rsp_idx == IW'(j), "R6 word offset", rsp_idx, j);
        chk(rsp_data == exp_word(a, j), "R6 word data", rsp_data, exp_word(a, j));
        chk(rsp_done == (j == NW - 1), "R7 done flag", rsp_done, (j == NW - 1));
        if (sq && j < NW - 1)
          chk(mem_go == NW'(1 << (j + 1)), "R5 next bank strobe", mem_go, 1 << (j + 1));
        j++;
      end else if (rsp_done) begin
        chk(0, "R7 done without word", rsp_done, 0);
      end
    end
    req_vld = 1'b0;
    tot = sq ? (1 + NW * (LAT + 1)) : (1 + LAT + NW);
    chk(c == tot, sq ? "R5 fill cycles" : "R4 fill cycles", c, tot);
    @(posedge clk); @(negedge clk);
    chk(busy == 1'b0, "R2 busy cleared", busy, 0);
    chk(rsp_vld == 1'b0, "R7 no fifth word", rsp_vld, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] addrs [6];
    addrs[0] = 16'h0000; addrs[1] = 16'hFFFF; addrs[2] = 16'h1234;
    addrs[3] = 16'hA5A5; addrs[4] = 16'h8001; addrs[5] = 16'h7FFE;
    repeat (3) @(negedge clk);
    chk(busy == 0 && rsp_vld == 0 && rsp_done == 0 && mem_go == 0,
        "R1 outputs in reset", {busy, rsp_vld, rsp_done, mem_go}, 0);
    @(posedge clk); rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && rsp_vld == 0 && rsp_done == 0 && mem_go == 0,
        "R1 outputs after reset", {busy, rsp_vld, rsp_done, mem_go}, 0);
    // sweep both modes, requests back to back
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 6; k++)
        run_req(addrs[k] ^ AW'(m * 16'h0F0F), m[0], 1'b0);
    // requests raised while busy must be ignored
    run_req(16'h4C21, 1'b0, 1'b1);
    for (int i = 0; i < 25; i++) begin
      @(posedge clk); @(negedge clk);
      if (rsp_vld || busy || mem_go != 0)
        chk(0, "R2 ignored request started a fetch", {busy, rsp_vld}, 0);
    end
    chk(busy == 0, "R2 idle after ignored request", busy, 0);
    run_req(16'hC3B7, 1'b1, 1'b1);
    for (int i = 0; i < 70; i++) begin
      @(posedge clk); @(negedge clk);
      if (rsp_vld || busy || mem_go != 0)
        chk(0, "R2 ignored request started a fetch", {busy, rsp_vld}, 0);
    end
    chk(rsp_vld == 0, "R2 no words after ignored request", rsp_vld, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule